// File: doc/BRIEF.md
# Host Command Register with Interrupt Moderation

This block holds the command word of a host controller: the enables that let the schedule engine walk the periodic and the asynchronous schedule, the frame list size, and the interrupt threshold. It also carries out the two behaviours those fields drive. A microframe timer collects pending status and delivers it only at the boundary of a software-chosen power-of-two number of microframes. A doorbell handshake lets software ask the schedule engine to drop its cached asynchronous state, and records completion in a status bit.

Software reaches two registers through one write port and one combinational read port. Address 0 selects the command word: threshold in bits [15:8], light-reset bit 5, list size in [4:3], doorbell bit 2, asynchronous enable bit 1 and periodic enable bit 0. Address 1 selects the status word: advance-done in bit 1 and transfer-event in bit 0, both cleared by writing 1. The schedule engine supplies the microframe tick, the halted flag, the eviction-complete pulse and the transfer-event pulse. The block returns the enables, the frame-index wrap mask, the doorbell state and one interrupt line.

Top module: `hc_cmd_reg`

## Requirements
- R1: After reset the command word reads 16'h0800 (threshold 8, all other fields 0), the status word reads 0, the interrupt line is low and the wrap mask is 10'h3FF.
- R2: While the halted input is 1, a command write whose bits [15:8] hold 01h, 02h, 04h, 08h, 10h, 20h or 40h loads that threshold; any other value, including 00h, loads 08h.
- R3: While the halted input is 0, command writes leave the threshold unchanged and still update the other command fields.
- R4: Command bit 0 drives the periodic enable output and bit 1 the asynchronous enable output; both read back.
- R5: With the programmable list option on, list size codes 00b, 01b and 10b in bits [4:3] give wrap masks 10'h3FF, 10'h1FF and 10'h0FF; a write of 11b leaves the previous size. With the option off, the size reads 00b and the mask stays 10'h3FF.
- R6: Writing 1 to command bit 2 sets the doorbell; the eviction pulse while the doorbell is set clears it and sets status bit 1 at the same clock edge. An eviction pulse with the doorbell clear has no effect.
- R7: Writing 1 to a status bit clears it; when a set event and a clearing write meet in one cycle, the bit ends set.
- R8: The interrupt line rises only at a threshold boundary, which is the threshold-th microframe tick after the last boundary or accepted threshold write, and only if a status bit whose enable input is 1 is set at that edge; a status bit set on the boundary cycle waits for the next boundary.
- R9: The interrupt line falls as soon as no enabled status bit remains set, and stays low until the next boundary finds one.
- R10: Command bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 command, 1 status |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 1 | Read address: 0 command, 1 status |
| rd_data_o | output | 16 | Read data, combinational |
| uframe_tick_i | input | 1 | One-cycle pulse per microframe |
| halted_i | input | 1 | Controller halted flag |
| evict_done_i | input | 1 | Engine has dropped cached asynchronous state |
| xfer_evt_i | input | 1 | Transfer-completion event pulse |
| irq_en_i | input | 2 | Enables for status bits 1 and 0 |
| periodic_en_o | output | 1 | Periodic schedule enable |
| async_en_o | output | 1 | Asynchronous schedule enable |
| doorbell_o | output | 1 | Doorbell pending toward the engine |
| frame_mask_o | output | 10 | Frame-index wrap mask |
| adv_sts_o | output | 1 | Advance-done status |
| irq_o | output | 1 | Interrupt line |

## Verification
Two pairs of functions can land on the same clock edge: a status set event and a software clear of that bit, and a new status event and the threshold boundary. The bench drives the eviction pulse together with a write of 1 to the advance bit, and the transfer pulse together with the boundary tick, in one cycle. The first is judged by reading the bit back as set; the second by seeing the line stay low at that boundary and rise only a full threshold later.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;

   localparam int unsigned DATA_W    = 16;
   localparam int unsigned THR_W     = 8;
   localparam int unsigned THR_LSB   = 8;
   localparam int unsigned MAX_LOG2  = 6;
   localparam int unsigned DEF_THR   = 8;
   localparam int unsigned FIDX_W    = 10;
   localparam int unsigned FLS_W     = 2;
   localparam int unsigned STS_W     = 2;

   localparam int unsigned BIT_PER   = 0;
   localparam int unsigned BIT_ASY   = 1;
   localparam int unsigned BIT_DB    = 2;
   localparam int unsigned FLS_LSB   = 3;
   localparam int unsigned BIT_LRST  = 5;

   localparam int unsigned STS_XFER  = 0;
   localparam int unsigned STS_ADV   = 1;

   typedef enum logic {
      REG_CMD = 1'b0,
      REG_STS = 1'b1
   } reg_sel_e;

   typedef enum logic [1:0] {
      LIST_1K   = 2'b00,
      LIST_512  = 2'b01,
      LIST_256  = 2'b10,
      LIST_RSVD = 2'b11
   } list_size_e;

endpackage

// File: rtl/hc_cmd_fields.sv
module hc_cmd_fields
   import hc_cmd_pkg::*;
#(
   parameter int unsigned P_DATA_W   = DATA_W,
   parameter int unsigned P_THR_W    = THR_W,
   parameter int unsigned P_MAX_LOG2 = MAX_LOG2,
   parameter int unsigned P_DEF_THR  = DEF_THR,
   parameter int unsigned P_FIDX_W   = FIDX_W,
   parameter bit          P_PROG_LIST = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cmd_we_i,
   input  logic [P_DATA_W-1:0]   wdata_i,
   input  logic                  halted_i,
   output logic [P_THR_W-1:0]    thr_o,
   output logic                  thr_load_o,
   output logic [FLS_W-1:0]      fls_o,
   output logic [P_FIDX_W-1:0]   mask_o,
   output logic                  per_en_o,
   output logic                  asy_en_o
);

   localparam int unsigned MAX_THR = 1 << P_MAX_LOG2;
   localparam logic [P_THR_W-1:0] THR_RST = P_THR_W'(P_DEF_THR);
   localparam logic [P_THR_W-1:0] THR_CAP = P_THR_W'(MAX_THR);

   initial begin
      if (P_DATA_W < THR_LSB + P_THR_W)
         $error("hc_cmd_fields: data word too narrow for threshold field");
      if (MAX_THR >= (1 << P_THR_W))
         $error("hc_cmd_fields: threshold field cannot hold largest threshold");
      if (P_FIDX_W < 3)
         $error("hc_cmd_fields: frame index too narrow");
   end

   logic [P_THR_W-1:0] thr_q;
   logic [P_THR_W-1:0] thr_wr;
   logic               thr_ok;
   logic               per_q, asy_q;
   logic [FLS_W-1:0]   fls_q;

   assign thr_wr = wdata_i[THR_LSB +: P_THR_W];
   assign thr_ok = (thr_wr != '0) && ((thr_wr & (thr_wr - 1'b1)) == '0)
                   && (thr_wr <= THR_CAP);

   logic unused_wdata;
   assign unused_wdata = ^{wdata_i[BIT_LRST], wdata_i[7:6], wdata_i[BIT_DB]};

   assign thr_load_o = cmd_we_i && halted_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_q <= THR_RST;
         per_q <= 1'b0;
         asy_q <= 1'b0;
      end else if (cmd_we_i) begin
         per_q <= wdata_i[BIT_PER];
         asy_q <= wdata_i[BIT_ASY];
         if (halted_i)
            thr_q <= thr_ok ? thr_wr : THR_RST;
      end
   end

   generate
      if (P_PROG_LIST) begin : g_prog_list
         logic [FLS_W-1:0] fls_wr;
         assign fls_wr = wdata_i[FLS_LSB +: FLS_W];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               fls_q <= LIST_1K;
            else if (cmd_we_i && (fls_wr != LIST_RSVD))
               fls_q <= fls_wr;
         end
      end else begin : g_fixed_list
         logic unused_fls;
         assign unused_fls = ^wdata_i[FLS_LSB +: FLS_W];
         assign fls_q = LIST_1K;
      end
   endgenerate

   assign mask_o   = {P_FIDX_W{1'b1}} >> fls_q;
   assign thr_o    = thr_q;
   assign fls_o    = fls_q;
   assign per_en_o = per_q;
   assign asy_en_o = asy_q;

   AST_THR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(thr_q) && (thr_q <= THR_CAP)); // R2
   AST_THR_FROZEN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !halted_i |=> $stable(thr_q)); // R3
   AST_FLS_NOT_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fls_q != LIST_RSVD); // R5

endmodule

// File: rtl/hc_uframe_timer.sv
module hc_uframe_timer
   import hc_cmd_pkg::*;
#(
   parameter int unsigned P_THR_W = THR_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tick_i,
   input  logic               load_i,
   input  logic [P_THR_W-1:0] thr_i,
   output logic               boundary_o
);

   logic [P_THR_W-1:0] cnt_q;
   logic               last;

   assign last       = (cnt_q == (thr_i - 1'b1));
   assign boundary_o = tick_i && !load_i && last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= last ? '0 : cnt_q + 1'b1;
   end

   AST_CNT_BELOW_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |-> cnt_q < thr_i); // R8
   AST_LOAD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cnt_q == '0); // R8

endmodule

// File: rtl/hc_doorbell.sv
module hc_doorbell
   import hc_cmd_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ring_i,
   input  logic [STS_W-1:0] w1c_i,
   input  logic             evict_i,
   input  logic             xfer_i,
   output logic             db_o,
   output logic [STS_W-1:0] sts_o
);

   logic             db_q;
   logic [STS_W-1:0] sts_q;
   logic             adv_set;

   assign adv_set = db_q && evict_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         db_q  <= 1'b0;
         sts_q <= '0;
      end else begin
         if (adv_set)
            db_q <= 1'b0;
         else if (ring_i)
            db_q <= 1'b1;
         sts_q[STS_ADV]  <= adv_set | (sts_q[STS_ADV]  & ~w1c_i[STS_ADV]);
         sts_q[STS_XFER] <= xfer_i  | (sts_q[STS_XFER] & ~w1c_i[STS_XFER]);
      end
   end

   assign db_o  = db_q;
   assign sts_o = sts_q;

   AST_DB_DROPS_ON_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sts_q[STS_ADV]) |-> !db_q); // R6
   AST_IDLE_EVICT_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!db_q && !sts_q[STS_ADV]) |=> !sts_q[STS_ADV]); // R6
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (db_q && evict_i) |=> sts_q[STS_ADV]); // R7

endmodule

// File: rtl/hc_irq_gate.sv
module hc_irq_gate
   import hc_cmd_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             boundary_i,
   input  logic [STS_W-1:0] sts_i,
   input  logic [STS_W-1:0] en_i,
   output logic             irq_o
);

   logic armed_q;
   logic pend;

   assign pend = |(sts_i & en_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         armed_q <= 1'b0;
      else if (boundary_i)
         armed_q <= pend;
      else
         armed_q <= armed_q && pend;
   end

   assign irq_o = armed_q && pend;

   AST_ARM_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(armed_q) |-> $past(boundary_i)); // R8
   AST_DISARM_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend && !boundary_i) |=> !armed_q); // R9

endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg
   import hc_cmd_pkg::*;
#(
   parameter bit P_PROG_LIST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              uframe_tick_i,
   input  logic              halted_i,
   input  logic              evict_done_i,
   input  logic              xfer_evt_i,
   input  logic [STS_W-1:0]  irq_en_i,
   output logic              periodic_en_o,
   output logic              async_en_o,
   output logic              doorbell_o,
   output logic [FIDX_W-1:0] frame_mask_o,
   output logic              adv_sts_o,
   output logic              irq_o
);

   logic              cmd_we, sts_we;
   logic [THR_W-1:0]  thr;
   logic              thr_load;
   logic [FLS_W-1:0]  fls;
   logic              boundary;
   logic              db;
   logic [STS_W-1:0]  sts;
   logic [STS_W-1:0]  w1c;

   assign cmd_we = wr_en_i && (wr_addr_i == REG_CMD);
   assign sts_we = wr_en_i && (wr_addr_i == REG_STS);
   assign w1c    = sts_we ? wr_data_i[STS_W-1:0] : '0;

   hc_cmd_fields #(
      .P_PROG_LIST(P_PROG_LIST)
   ) u_fields (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_we_i   (cmd_we),
      .wdata_i    (wr_data_i),
      .halted_i   (halted_i),
      .thr_o      (thr),
      .thr_load_o (thr_load),
      .fls_o      (fls),
      .mask_o     (frame_mask_o),
      .per_en_o   (periodic_en_o),
      .asy_en_o   (async_en_o)
   );

   hc_uframe_timer u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (uframe_tick_i),
      .load_i     (thr_load),
      .thr_i      (thr),
      .boundary_o (boundary)
   );

   hc_doorbell u_doorbell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ring_i  (cmd_we && wr_data_i[BIT_DB]),
      .w1c_i   (w1c),
      .evict_i (evict_done_i),
      .xfer_i  (xfer_evt_i),
      .db_o    (db),
      .sts_o   (sts)
   );

   hc_irq_gate u_irq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .boundary_i (boundary),
      .sts_i      (sts),
      .en_i       (irq_en_i),
      .irq_o      (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == REG_CMD) begin
         rd_data_o[THR_LSB +: THR_W] = thr;
         rd_data_o[FLS_LSB +: FLS_W] = fls;
         rd_data_o[BIT_DB]           = db;
         rd_data_o[BIT_ASY]          = async_en_o;
         rd_data_o[BIT_PER]          = periodic_en_o;
         rd_data_o[BIT_LRST]         = 1'b0;
      end else begin
         rd_data_o[STS_W-1:0] = sts;
      end
   end

   assign doorbell_o = db;
   assign adv_sts_o  = sts[STS_ADV];

   AST_MASK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot({1'b0, frame_mask_o} + 1'b1)); // R5
   AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(boundary) || $past(irq_o) || $past(|(sts & irq_en_i)) == 1'b0); // R8

endmodule

// File: tb/hc_cmd_reg_bench.sv
module hc_cmd_reg_bench;
   import hc_cmd_pkg::*;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              wr_addr = 1'b0;
   logic [15:0]       wr_data = '0;
   logic              rd_addr = 1'b0;
   logic [15:0]       rd_data, rd_data_f;
   logic              tick = 1'b0;
   logic              halted = 1'b1;
   logic              evict = 1'b0;
   logic              xfer = 1'b0;
   logic [1:0]        ien = 2'b00;
   logic              per_en, asy_en, db, adv, irq;
   logic              per_f, asy_f, db_f, adv_f, irq_f;
   logic [9:0]        mask, mask_f;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   hc_cmd_reg u_hc_cmd_reg (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .uframe_tick_i(tick), .halted_i(halted), .evict_done_i(evict),
      .xfer_evt_i(xfer), .irq_en_i(ien), .periodic_en_o(per_en),
      .async_en_o(asy_en), .doorbell_o(db), .frame_mask_o(mask),
      .adv_sts_o(adv), .irq_o(irq));

   hc_cmd_reg #(.P_PROG_LIST(1'b0)) u_hc_cmd_reg_fixed (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data_f),
      .uframe_tick_i(tick), .halted_i(halted), .evict_done_i(evict),
      .xfer_evt_i(xfer), .irq_en_i(ien), .periodic_en_o(per_f),
      .async_en_o(asy_f), .doorbell_o(db_f), .frame_mask_o(mask_f),
      .adv_sts_o(adv_f), .irq_o(irq_f));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] cmdw(input logic [7:0] t, input logic [1:0] f,
                                        input logic d, input logic a, input logic p);
      return {t, 3'b000, f, d, a, p};
   endfunction

   function automatic logic [7:0] coerce(input logic [7:0] v);
      logic ok;
      ok = (v != 0) && ((v & (v - 8'd1)) == 0) && (v <= 8'h40);
      return ok ? v : 8'h08;
   endfunction

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic pulse_evict();
      @(negedge clk); evict = 1'b1;
      @(negedge clk); evict = 1'b0;
   endtask

   task automatic pulse_xfer();
      @(negedge clk); xfer = 1'b1;
      @(negedge clk); xfer = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [15:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         n_bad++; n_vec++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [7:0]  cur_thr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(REG_CMD, d); chk("R1 cmd", d, 16'h0800);
      rd(REG_STS, d); chk("R1 sts", d, 16'h0000);
      chk("R1 irq", {15'd0, irq}, 16'd0);
      chk("R1 mask", {6'd0, mask}, 16'h03FF);

      // R2 threshold sweep over every byte while halted
      halted = 1'b1;
      for (int v = 0; v < 256; v++) begin
         wr(REG_CMD, cmdw(8'(v), 2'b00, 1'b0, 1'b0, 1'b0));
         rd(REG_CMD, d);
         chk("R2 thr", {8'd0, d[15:8]}, {8'd0, coerce(8'(v))});
      end
      cur_thr = coerce(8'hFF);

      // R3 running: threshold frozen, enables still written
      wr(REG_CMD, cmdw(8'h40, 2'b00, 1'b0, 1'b0, 1'b0));
      cur_thr = 8'h40;
      halted = 1'b0;
      wr(REG_CMD, cmdw(8'h02, 2'b00, 1'b0, 1'b1, 1'b1));
      rd(REG_CMD, d);
      chk("R3 thr kept", {8'd0, d[15:8]}, {8'd0, cur_thr});
      chk("R3 R4 en", {14'd0, asy_en, per_en}, 16'h0003);

      // R4 enable combinations
      for (int e = 0; e < 4; e++) begin
         wr(REG_CMD, cmdw(8'h40, 2'b00, 1'b0, e[1], e[0]));
         rd(REG_CMD, d);
         chk("R4 outs", {14'd0, asy_en, per_en}, 16'(e));
         chk("R4 read", {14'd0, d[1:0]}, 16'(e));
      end
      halted = 1'b1;

      // R5 list size sweep on both variants
      for (int f = 0; f < 4; f++) begin
         logic [9:0] expm;
         wr(REG_CMD, cmdw(8'h08, 2'(f), 1'b0, 1'b0, 1'b0));
         expm = (f == 0) ? 10'h3FF : (f == 1) ? 10'h1FF : 10'h0FF;
         chk("R5 mask", {6'd0, mask}, {6'd0, expm});
         chk("R5 fixed mask", {6'd0, mask_f}, 16'h03FF);
         rd_addr = REG_CMD; #1;
         chk("R5 fixed fls", {14'd0, rd_data_f[4:3]}, 16'd0);
      end

      // R10 light-reset bit reads 0 even after writing all ones
      wr(REG_CMD, 16'hFFFF);
      rd(REG_CMD, d);
      chk("R10 bit5", {15'd0, d[5]}, 16'd0);
      chk("R2 R6 all-ones cmd", d, 16'h0817);

      // R6 doorbell handshake
      pulse_evict();
      chk("R6 db clear", {15'd0, db}, 16'd0);
      chk("R6 adv set", {15'd0, adv}, 16'd1);
      wr(REG_STS, 16'h0002);
      chk("R7 adv w1c", {15'd0, adv}, 16'd0);
      pulse_evict();
      chk("R6 idle evict", {15'd0, adv}, 16'd0);
      wr(REG_CMD, cmdw(8'h08, 2'b00, 1'b1, 1'b1, 1'b0));
      chk("R6 db rung", {15'd0, db}, 16'd1);
      @(negedge clk); evict = 1'b1; wr_en = 1'b1; wr_addr = REG_STS; wr_data = 16'h0002;
      @(negedge clk); evict = 1'b0; wr_en = 1'b0; wr_data = '0;
      chk("R7 set beats clear", {15'd0, adv}, 16'd1);
      chk("R6 db after", {15'd0, db}, 16'd0);
      wr(REG_STS, 16'h0002);
      chk("R7 adv cleared", {15'd0, adv}, 16'd0);
      @(negedge clk); xfer = 1'b1; wr_en = 1'b1; wr_addr = REG_STS; wr_data = 16'h0001;
      @(negedge clk); xfer = 1'b0; wr_en = 1'b0; wr_data = '0;
      rd(REG_STS, d); chk("R7 xfer set wins", d, 16'h0001);
      wr(REG_STS, 16'h0001);
      rd(REG_STS, d); chk("R7 xfer w1c", d, 16'h0000);

      // R8 R9 threshold timing across every legal threshold
      ien = 2'b01;
      for (int k = 0; k < 7; k++) begin
         int t;
         t = 1 << k;
         pulse_xfer();
         wr(REG_CMD, cmdw(8'(t), 2'b00, 1'b0, 1'b0, 1'b0));
         for (int i = 0; i < t - 1; i++) begin
            do_tick();
            chk("R8 early", {15'd0, irq}, 16'd0);
         end
         do_tick();
         chk("R8 boundary", {15'd0, irq}, 16'd1);
         ien = 2'b00; #1;
         chk("R9 enable drop", {15'd0, irq}, 16'd0);
         @(negedge clk);
         ien = 2'b01; #1;
         chk("R9 stays low", {15'd0, irq}, 16'd0);
         wr(REG_STS, 16'h0003);
      end

      // R8 disabled status raises nothing; R9 clear drops line
      ien = 2'b10;
      pulse_xfer();
      wr(REG_CMD, cmdw(8'h01, 2'b00, 1'b0, 1'b0, 1'b0));
      do_tick();
      chk("R8 masked", {15'd0, irq}, 16'd0);
      ien = 2'b01;
      do_tick();
      chk("R8 unmasked", {15'd0, irq}, 16'd1);
      wr(REG_STS, 16'h0001);
      chk("R9 w1c drop", {15'd0, irq}, 16'd0);

      // R8 status arriving on the boundary cycle waits one period
      wr(REG_CMD, cmdw(8'h02, 2'b00, 1'b0, 1'b0, 1'b0));
      do_tick();
      @(negedge clk); tick = 1'b1; xfer = 1'b1;
      @(negedge clk); tick = 1'b0; xfer = 1'b0;
      chk("R8 same-cycle low", {15'd0, irq}, 16'd0);
      do_tick();
      chk("R8 mid low", {15'd0, irq}, 16'd0);
      do_tick();
      chk("R8 next boundary", {15'd0, irq}, 16'd1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule